// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block is a shared bank of 2048 bytes of counter storage reached through a single request port with a valid/ready handshake. Any naturally aligned group of 1, 2, 4 or 8 bytes can be treated as a counter. Each accepted request performs one atomic read-modify-write on that group. A read-type request carries a signed 22-bit increment inside its address. A write-type request either adds its store data to the counter or overwrites the counter with it. Every accepted request produces exactly one response beat, which carries the counter's value from before the update.

A read-type request can ask to wait for an external tag-switch completion pulse before it touches storage. If that pulse does not arrive within a parameterized number of cycles, the request is abandoned. Its response then carries an error flag in bit 63, and storage is left as it was. Requesters that number bytes little-endian assert a per-request flag. The block then adjusts sub-word indices so that they land on the correct lanes of the big-endian byte array.

After reset the bank clears itself, one 64-bit word per cycle, and refuses requests until the clear is done.

Top module: `fau_unit`

## Requirements
- R1: After reset, `req_ready` stays low for the whole clear sequence and no response is issued. Once the clear ends, every byte reads as zero.
- R2: `req_size` selects the counter width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit. `req_addr[10:0]` is the byte index. Storage is big-endian: byte index 8k is bits 63:56 of the 64-bit counter at 8k.
- R3: For a read request (`req_write`=0), `req_addr[35:14]` is a signed increment. It is sign-extended, added modulo the counter width, and the response carries the old value sign-extended to 64 bits.
- R4: For a write request, `req_addr[13]`=0 adds the low bytes of `req_wdata` modulo the width, and `req_addr[13]`=1 replaces the counter with them. The response returns the old value sign-extended to 64 bits. Bytes outside the counter are never changed.
- R5: For a read request, `req_addr[13]`=1 holds the update until a `tag_done` pulse. The response then has bit 63 at 0, and bits 62:0 hold the old value's low (width-1) bits sign-extended.
- R6: If `tag_done` does not arrive within TIMEOUT cycles of acceptance, the response is 0x8000_0000_0000_0000 with `rsp_err`=0, and the counter is unchanged.
- R7: With `req_le`=1, the byte index is XORed with 7 for 8-bit, 6 for 16-bit and 4 for 32-bit accesses. It is not changed for 64-bit accesses.
- R8: A request whose (adjusted) index is not a multiple of its width gets a response with `rsp_err`=1 and data 0 on the cycle after acceptance. Storage is unchanged.
- R9: Requests are handled one at a time. Each update sees the result of all earlier ones, and `rsp_valid` is a single-cycle pulse for each accepted request.
- R10: A request that does not wait and is aligned responds three clock edges after the acceptance edge, with `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts the clear |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write-type request, 0 = read-type |
| req_le | input | 1 | Requester uses little-endian byte numbering |
| req_size | input | 2 | Counter width code |
| req_addr | input | 36 | Byte index, mode flag and read increment |
| req_wdata | input | 64 | Store data for write-type requests |
| tag_done | input | 1 | Tag-switch completion pulse |
| rsp_valid | output | 1 | Response beat |
| rsp_err | output | 1 | Misaligned request |
| rsp_data | output | 64 | Old counter value or timeout flag |

## Verification
A wrong lane shift or a wrong mask corrupts neighbouring bytes, but nothing appears at the ports until a later response reads those bytes back. For that reason the bench reads back whole 64-bit words after every sub-word update. A stale read register or a lost write shows up in the very next response to the same counter, because each response is the value just before the update. A timer that miscounts shows up only as a timeout response in the wrong place, or a success response in the wrong place. Back-to-back adds and both wait outcomes are therefore checked against a byte-accurate model.

// File: rtl/fau_pkg.sv
package fau_pkg;
  localparam int ADDR_W   = 36;
  localparam int INC_W    = 22;
  localparam int INC_LSB  = 14;
  localparam int FLAG_BIT = 13;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} fau_size_e;

  typedef struct packed {
    logic       is_write;
    logic       flag;      // no-add on writes, tag-wait on reads
    fau_size_e  size;
    logic [63:0] operand;
  } fau_cmd_t;
endpackage

// File: rtl/fau_decode.sv
module fau_decode
  import fau_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic              le,
  input  logic [63:0]       wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              aligned,
  output fau_cmd_t          cmd
);
  fau_size_e sz;
  logic [2:0] swz;
  logic unused_addr_bits;

  assign sz = fau_size_e'(size);
  assign unused_addr_bits = ^addr[FLAG_BIT-1:IDX_W];

  always_comb begin
    unique case (sz)
      SZ8:     swz = 3'd7;
      SZ16:    swz = 3'd6;
      SZ32:    swz = 3'd4;
      default: swz = 3'd0;
    endcase
    idx = addr[IDX_W-1:0] ^ {{(IDX_W-3){1'b0}}, (le ? swz : 3'd0)};
    unique case (sz)
      SZ8:     aligned = 1'b1;
      SZ16:    aligned = (idx[0] == 1'b0);
      SZ32:    aligned = (idx[1:0] == 2'b00);
      default: aligned = (idx[2:0] == 3'b000);
    endcase
    cmd.is_write = write;
    cmd.flag     = addr[FLAG_BIT];
    cmd.size     = sz;
    cmd.operand  = write ? wdata
                 : {{(64-INC_W){addr[INC_LSB+INC_W-1]}}, addr[INC_LSB+INC_W-1:INC_LSB]};
  end
endmodule

// File: rtl/fau_lane.sv
module fau_lane
  import fau_pkg::*;
(
  input  logic [63:0] old_word,
  input  logic [2:0]  off,
  input  fau_size_e   size,
  input  logic [63:0] operand,
  input  logic        overwrite,
  output logic [63:0] new_word,
  output logic [63:0] old_full,
  output logic [62:0] old_narrow
);
  logic [2:0]  nm1;
  logic [2:0]  byte_pos;
  logic [5:0]  shamt;
  logic [63:0] mask, field, sum;
  logic [63:0] narrow64;

  always_comb begin
    unique case (size)
      SZ8:     begin nm1 = 3'd0; mask = 64'hFF; end
      SZ16:    begin nm1 = 3'd1; mask = 64'hFFFF; end
      SZ32:    begin nm1 = 3'd3; mask = 64'hFFFF_FFFF; end
      default: begin nm1 = 3'd7; mask = '1; end
    endcase
    // big-endian lanes: last byte of the counter sits at the lowest shift
    byte_pos = 3'd7 - off - nm1;
    shamt    = {byte_pos, 3'b000};
    field    = (old_word >> shamt) & mask;
    sum      = (overwrite ? operand : (field + operand)) & mask;
    new_word = (old_word & ~(mask << shamt)) | (sum << shamt);
    unique case (size)
      SZ8:  begin old_full = {{56{field[7]}},  field[7:0]};  narrow64 = {{57{field[6]}},  field[6:0]};  end
      SZ16: begin old_full = {{48{field[15]}}, field[15:0]}; narrow64 = {{49{field[14]}}, field[14:0]}; end
      SZ32: begin old_full = {{32{field[31]}}, field[31:0]}; narrow64 = {{33{field[30]}}, field[30:0]}; end
      default: begin old_full = field; narrow64 = {1'b0, field[62:0]}; end
    endcase
    old_narrow = narrow64[62:0];
  end
endmodule

// File: rtl/fau_wait_timer.sv
module fau_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic tag_done,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  assign expired = run && !tag_done && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || start)          cnt <= '0;
    else if (run && !tag_done) cnt <= cnt + 1'b1;
  end

  // R6: the wait window never runs past its limit
  p_wait_bound_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CNT_W'(LIMIT)));
endmodule

// File: rtl/fau_unit.sv
module fau_unit
  import fau_pkg::*;
#(
  parameter int BYTES   = 2048,
  parameter int TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_le,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic              tag_done,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_data
);
  localparam int WORDS  = BYTES / 8;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(BYTES);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_READ, S_EXEC} state_e;
  state_e state;

  logic [63:0]       mem [WORDS];
  logic [63:0]       rd_q;
  logic              clr_busy;
  logic [WIDX_W-1:0] clr_idx;
  fau_cmd_t          cmd_d, cmd_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic              aligned_d, accept, expired;
  logic [63:0]       new_word, old_full;
  logic [62:0]       old_narrow;
  logic              mem_we;
  logic [WIDX_W-1:0] mem_waddr;
  logic [63:0]       mem_wdata;

  fau_decode #(.IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write), .le(req_le),
    .wdata(req_wdata), .idx(idx_d), .aligned(aligned_d), .cmd(cmd_d));

  fau_lane u_lane (
    .old_word(rd_q), .off(idx_q[2:0]), .size(cmd_q.size), .operand(cmd_q.operand),
    .overwrite(cmd_q.is_write && cmd_q.flag),
    .new_word(new_word), .old_full(old_full), .old_narrow(old_narrow));

  fau_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .run(state == S_WAIT),
    .tag_done(tag_done), .expired(expired));

  assign req_ready = (state == S_IDLE) && !clr_busy && !rsp_valid;
  assign accept    = req_valid && req_ready;

  assign mem_we    = clr_busy || (state == S_EXEC);
  assign mem_waddr = clr_busy ? clr_idx : idx_q[IDX_W-1:3];
  assign mem_wdata = clr_busy ? 64'd0 : new_word;

  // single write port, registered read port
  always_ff @(posedge clk) begin
    if (mem_we)           mem[mem_waddr] <= mem_wdata;
    if (state == S_READ)  rd_q <= mem[idx_q[IDX_W-1:3]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      clr_busy  <= 1'b1;
      clr_idx   <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      cmd_q     <= '0;
      idx_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (clr_busy) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == WIDX_W'(WORDS - 1)) clr_busy <= 1'b0;
      end
      unique case (state)
        S_IDLE: if (accept) begin
          if (!aligned_d) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
          end else begin
            cmd_q <= cmd_d;
            idx_q <= idx_d;
            state <= (!cmd_d.is_write && cmd_d.flag) ? S_WAIT : S_READ;
          end
        end
        S_WAIT: begin
          if (tag_done) state <= S_READ;
          else if (expired) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_data  <= {1'b1, 63'd0};
            state     <= S_IDLE;
          end
        end
        S_READ: state <= S_EXEC;
        default: begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_data  <= (!cmd_q.is_write && cmd_q.flag) ? {1'b0, old_narrow} : old_full;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  // R1: no response while the clear runs
  p_quiet_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> !rsp_valid);
  // R8: misaligned request answered next cycle with an error and no data
  p_misalign_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && !aligned_d) |=> (rsp_valid && rsp_err && rsp_data == 64'd0));
  // R10: aligned non-waiting request answers three edges after acceptance
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (accept && aligned_d && !(!req_write && req_addr[FLAG_BIT])) |=> ##2 (rsp_valid && !rsp_err));
  // R9: each response is a single-cycle pulse
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R5: without a tag event, a waiting request can only end in a timeout beat
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !tag_done) |=> (!rsp_valid || rsp_data[63]));
endmodule

// File: tb/fau_unit_tb_top.sv
module fau_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, req_valid, req_ready, req_write, req_le, tag_done;
  logic [1:0]  req_size;
  logic [35:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_data;

  fau_unit #(.TIMEOUT(16)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_le(req_le), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .tag_done(tag_done),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data));

  typedef struct { logic err; logic [63:0] data; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] model [2048];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] sx(logic [63:0] v, int bits);
    logic signed [63:0] t;
    t = signed'(v << (64 - bits));
    return 64'(t >>> (64 - bits));
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected response", {rsp_err, rsp_data}, '0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_err == e.err && rsp_data == e.data, e.tag, {rsp_err, rsp_data}, {e.err, e.data});
      end
    end
  end

  // driver: tag_delay < 0 means no tag event
  task automatic issue(bit wr, bit le, bit flag, logic [1:0] sz, logic [10:0] idx,
                       logic [21:0] inc, logic [63:0] wd, int tag_delay, bit lat, string tag);
    logic [10:0] a;
    logic [2:0]  swz;
    int n;
    logic [63:0] old, opnd, nv, mask;
    exp_t e;
    swz = (sz == 0) ? 3'd7 : (sz == 1) ? 3'd6 : (sz == 2) ? 3'd4 : 3'd0;
    a = le ? (idx ^ {8'd0, swz}) : idx;
    n = 1 << sz;
    mask = (n == 8) ? '1 : ((64'd1 << (8*n)) - 1);
    e.tag = tag;
    if ((int'(a) % n) != 0) begin
      e.err = 1'b1; e.data = '0;
    end else begin
      old = '0;
      for (int i = 0; i < n; i++) old = (old << 8) | 64'(model[int'(a) + i]);
      e.err = 1'b0;
      if (!wr && flag && tag_delay < 0) e.data = {1'b1, 63'd0};
      else begin
        opnd = wr ? wd : {{42{inc[21]}}, inc};
        nv = ((wr && flag) ? opnd : (old + opnd)) & mask;
        for (int i = n - 1; i >= 0; i--) begin
          model[int'(a) + i] = nv[7:0];
          nv = nv >> 8;
        end
        if (!wr && flag) e.data = {1'b0, sx(old, 8*n - 1)} & {1'b0, {63{1'b1}}};
        else             e.data = sx(old, 8*n);
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_le = le; req_size = sz; req_wdata = wd;
    req_addr = {inc, flag, 2'b00, idx};
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
    if (lat) begin
      @(negedge clk); check(rsp_valid == 0, "R10 early response", 65'(rsp_valid), 65'd0);
      @(negedge clk); check(rsp_valid == 0, "R10 early response", 65'(rsp_valid), 65'd0);
      @(negedge clk); check(rsp_valid == 1, "R10 response timing", 65'(rsp_valid), 65'd1);
    end
    if (tag_delay >= 0 && !wr && flag) begin
      repeat (tag_delay) @(negedge clk);
      tag_done = 1;
      @(negedge clk);
      tag_done = 0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", '0, '0);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = 8'd0;
    rst = 1; req_valid = 0; req_write = 0; req_le = 0; req_size = 0;
    req_addr = '0; req_wdata = '0; tag_done = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (100) @(negedge clk);
    check(req_ready == 0, "R1 ready during clear", 65'(req_ready), 65'd0);
    begin
      int w = 0;
      while (!req_ready && w < 400) begin @(negedge clk); w++; end
      check(req_ready == 1, "R1 ready after clear", 65'(req_ready), 65'd1);
    end
    // R1: cleared contents; R10 timing
    issue(0, 0, 0, 2'd3, 11'd0,    22'd0, '0, -1, 1, "R1 word 0 cleared");
    issue(0, 0, 0, 2'd0, 11'd2047, 22'd0, '0, -1, 0, "R1 last byte cleared");
    // R3: immediate increments, signed, wrap
    issue(0, 0, 0, 2'd3, 11'd8, 22'd5, '0, -1, 0, "R3 add 5");
    issue(0, 0, 0, 2'd3, 11'd8, -22'sd3, '0, -1, 0, "R3 add -3");
    issue(0, 0, 0, 2'd3, 11'd8, 22'h1FFFFF, '0, -1, 0, "R3 max increment");
    issue(0, 0, 0, 2'd3, 11'd8, 22'h200000, '0, -1, 0, "R3 min increment");
    issue(0, 0, 0, 2'd3, 11'd8, 22'd0, '0, -1, 0, "R3 readback");
    issue(0, 0, 0, 2'd0, 11'd16, 22'd200, '0, -1, 0, "R3 byte add");
    issue(0, 0, 0, 2'd0, 11'd16, 22'd100, '0, -1, 0, "R3 byte sign extend");
    issue(0, 0, 0, 2'd3, 11'd16, 22'd0, '0, -1, 0, "R3 byte wrap neighbours");
    // R4: store add and overwrite
    issue(1, 0, 0, 2'd3, 11'd24, 22'd0, 64'd100, -1, 0, "R4 store add");
    issue(1, 0, 0, 2'd3, 11'd24, 22'd0, 64'd50, -1, 0, "R4 store add again");
    issue(1, 0, 1, 2'd2, 11'd24, 22'd0, 64'h1234_5678_DEAD_BEEF, -1, 0, "R4 overwrite upper half");
    issue(1, 0, 1, 2'd0, 11'd33, 22'd0, 64'hA5, -1, 0, "R4 overwrite byte");
    issue(0, 0, 0, 2'd3, 11'd24, 22'd0, '0, -1, 0, "R4 R2 word after overwrite");
    issue(0, 0, 0, 2'd3, 11'd32, 22'd0, '0, -1, 0, "R4 neighbours intact");
    // R7 / R2: little-endian swizzle versus big-endian lanes
    issue(1, 1, 1, 2'd3, 11'd40, 22'd0, 64'h0102_0304_0506_0708, -1, 0, "R7 64-bit unswizzled");
    issue(0, 1, 0, 2'd0, 11'd40, 22'd0, '0, -1, 0, "R7 le byte");
    issue(0, 1, 0, 2'd1, 11'd40, 22'd0, '0, -1, 0, "R7 le half");
    issue(0, 1, 0, 2'd2, 11'd40, 22'd0, '0, -1, 0, "R7 le word");
    issue(0, 0, 0, 2'd0, 11'd40, 22'd0, '0, -1, 0, "R2 big-endian byte 0");
    // R5: tag wait completes
    issue(0, 0, 1, 2'd1, 11'd48, 22'd7, '0, 3, 0, "R5 tag wait add");
    issue(1, 0, 1, 2'd1, 11'd48, 22'd0, 64'h8001, -1, 0, "R5 prepare");
    issue(0, 0, 1, 2'd1, 11'd48, 22'd0, '0, 5, 0, "R5 narrow value field");
    // R6: timeout leaves storage unchanged
    issue(1, 0, 1, 2'd2, 11'd56, 22'd0, 64'h0000_0009, -1, 0, "R6 prepare");
    issue(0, 0, 1, 2'd2, 11'd56, 22'd4, '0, -1, 0, "R6 timeout flag");
    issue(0, 0, 0, 2'd2, 11'd56, 22'd0, '0, -1, 0, "R6 storage unchanged");
    // R8: misaligned
    issue(1, 0, 1, 2'd2, 11'd58, 22'd0, 64'hFFFF, -1, 0, "R8 misaligned error");
    issue(0, 0, 0, 2'd1, 11'd57, 22'd1, '0, -1, 0, "R8 misaligned half");
    issue(0, 0, 0, 2'd3, 11'd56, 22'd0, '0, -1, 0, "R8 storage unchanged");
    // R9: back-to-back serialised updates
    for (int k = 0; k < 5; k++)
      issue(0, 0, 0, 2'd0, 11'd100, 22'd60, '0, -1, 0, "R9 back-to-back");
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R9 missing responses", 65'(exp_q.size()), 65'd0);
    done = 1;
    finish_run();
  end
endmodule